// File: doc/BRIEF.md
# Dual-Transceiver Redundancy Manager

This block supervises a pair of identical radio transceivers, unit A and unit B, that keep their settings in registers an upset can corrupt. It drives per-unit power, enable and configuration-request lines, watches the per-unit configuration-done lines, and passes one of the two incoming sample streams to a single output. Bit 0 of every two-bit per-unit bus belongs to unit A and bit 1 to unit B.

Software picks one of three redundancy schemes through `mode_sel`. In cold standby only A runs until software declares it dead; B is then powered, configured and switched in. In parallel comparison both units run on the same settings while A's samples are forwarded; the two streams are compared and a run of disagreeing samples raises a fault. In periodic toggling one unit carries traffic while the other is reconfigured. The roles swap once that reconfiguration is done and a programmable interval has elapsed, so every unit is refreshed in turn. A configuration that misses its deadline retires the unit and leaves traffic on the healthy one.

Top module: `xcvr_redund_mgr`

## Requirements
- R1: `mode_sel` encodes 0 = cold standby, 1 = comparison, 2 = toggling, 3 = cold standby. Synchronous reset, or any change of `mode_sel`, takes effect at the next clock edge and returns the block to A active with B idle, no unit failed, `fault` low and the mismatch run cleared.
- R2: In cold standby with A healthy, A is powered and enabled, B is unpowered and disabled, and `active_unit` is 0.
- R3: In cold standby, a `prim_fail` pulse while A is active marks A failed and unpowers it, powers B and requests B's configuration; B is enabled once its done is seen, and later `prim_fail` pulses are ignored.
- R4: In comparison mode both units are powered and enabled, no configuration is requested, and unit A's samples are forwarded.
- R5: In comparison mode a valid sample mismatches when |A − B| exceeds `diff_thresh`; `fault` rises at the edge of the `mismatch_limit`-th consecutive mismatch (a limit of 0 acts as 1), a matching sample restarts the run, and `fault` stays high until reset or mode change.
- R6: In toggling mode exactly the active unit is enabled, the standby unit is powered but disabled, and its `cfg_req` stays high from the start of its reconfiguration until its done is seen.
- R7: A toggle swap happens only after the standby unit's done has been seen and the timer, started at the beginning of the reconfiguration and incremented every cycle, has reached `toggle_interval`; the former active unit is then put into reconfiguration.
- R8: If a requested unit gives no done before its timer exceeds `cfg_timeout`, it is marked failed in `unit_failed` and unpowered, its request drops, traffic stays on the other unit and no further swap occurs.
- R9: `out_vld` rises one cycle after a `samp_vld` strobe during which the active unit was enabled, and `out_data` then carries that unit's whole sample from the strobe cycle.
- R10: At most one `cfg_req` bit is high at any time, and a failed unit is never powered or enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Redundancy scheme select |
| prim_fail | input | 1 | Pulse declaring the cold-standby primary permanently failed |
| toggle_interval | input | TW | Minimum cycles between the start of a reconfiguration and the swap |
| cfg_timeout | input | TW | Cycles allowed for a unit's configuration to finish |
| diff_thresh | input | DW | Largest sample difference still treated as agreement |
| mismatch_limit | input | CW | Consecutive mismatches needed to raise the fault |
| cfg_done | input | 2 | Per-unit configuration finished |
| cfg_req | output | 2 | Per-unit configuration request |
| unit_pwr | output | 2 | Per-unit power control |
| unit_en | output | 2 | Per-unit enable |
| samp_vld | input | 1 | Both input samples valid this cycle |
| samp_a | input | DW | Sample from unit A |
| samp_b | input | DW | Sample from unit B |
| out_vld | output | 1 | Output sample valid |
| out_data | output | DW | Selected output sample |
| active_unit | output | 1 | Unit carrying traffic (0 = A, 1 = B) |
| unit_failed | output | 2 | Per-unit failed marker |
| fault | output | 1 | Comparison-mode divergence fault |

## Verification
The bench builds the block with its default widths (12-bit samples, 24-bit timers, 8-bit run counter) but drives interval and timeout values of a few tens of cycles, so many swap rounds and a configuration deadline fit in a short run. Configuration times of the emulated units are chosen both shorter and longer than the interval, so swaps gated by the timer and swaps gated by done both occur, and an endless configuration reaches the timeout. A mismatch limit of 4 and a threshold of 3 put the exact-threshold difference, the interrupted run and the limit-of-zero case within a handful of samples.

// File: rtl/xr_pkg.sv
package xr_pkg;

    typedef enum logic [1:0] {
        MD_COLD = 2'd0,
        MD_CMP  = 2'd1,
        MD_TGL  = 2'd2,
        MD_RSV  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CFG  = 2'd1,
        ST_WAIT = 2'd2,
        ST_HOLD = 2'd3
    } st_e;

    // Per-unit control bundle driven by the sequencer (bit 0 = A, bit 1 = B)
    typedef struct packed {
        logic [1:0] pwr;
        logic [1:0] en;
        logic [1:0] req;
        logic       act;
    } unit_ctl_t;

    // The reserved encoding falls back to cold standby
    function automatic mode_e dec_mode(input logic [1:0] m);
        return (m == 2'd3) ? MD_COLD : mode_e'(m);
    endfunction

endpackage

// File: rtl/xr_ctrl.sv
module xr_ctrl
    import xr_pkg::*;
#(
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          clr,
    input  mode_e         mode,
    input  logic          prim_fail,
    input  logic [1:0]    cfg_done,
    input  logic [TW-1:0] interval,
    input  logic [TW-1:0] timeout,
    output unit_ctl_t     ctl,
    output logic [1:0]    failed
);

    st_e           st;
    logic          act;
    logic          tgt;
    logic [TW-1:0] tmr;
    logic [TW-1:0] tmr_inc;
    logic [1:0]    pwr_v;
    logic [1:0]    en_v;
    logic [1:0]    req_v;

    // Unit under configuration: the standby one when toggling, else the active one
    assign tgt     = (mode == MD_TGL) ? ~act : act;
    assign tmr_inc = (&tmr) ? tmr : tmr + 1'b1;

    always_ff @(posedge clk) begin
        if (clr) begin
            st     <= ST_IDLE;
            act    <= 1'b0;
            tmr    <= '0;
            failed <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (mode == MD_TGL) begin
                        st  <= ST_CFG;
                        tmr <= '0;
                    end else if (mode == MD_COLD && prim_fail) begin
                        failed[act] <= 1'b1;
                        act         <= ~act;
                        st          <= ST_CFG;
                        tmr         <= '0;
                    end
                end
                ST_CFG: begin
                    tmr <= tmr_inc;
                    if (cfg_done[tgt]) begin
                        st <= (mode == MD_TGL) ? ST_WAIT : ST_HOLD;
                    end else if (tmr >= timeout) begin
                        failed[tgt] <= 1'b1;
                        st          <= ST_HOLD;
                    end
                end
                ST_WAIT: begin
                    tmr <= tmr_inc;
                    if (tmr >= interval) begin
                        act <= ~act;
                        st  <= ST_CFG;
                        tmr <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    for (genvar u = 0; u < 2; u++) begin : g_unit
        localparam bit UB = (u != 0);
        logic is_act;
        assign is_act   = (act == UB);
        assign pwr_v[u] = !failed[u] && (mode != MD_COLD || is_act);
        assign en_v[u]  = !failed[u] &&
                          (mode == MD_CMP || (is_act && !(mode == MD_COLD && st == ST_CFG)));
        assign req_v[u] = (st == ST_CFG) && (tgt == UB);
    end

    assign ctl = '{pwr: pwr_v, en: en_v, req: req_v, act: act};

endmodule

// File: rtl/xr_cmp.sv
module xr_cmp #(
    parameter int DW = 12,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          run_en,
    input  logic          samp_vld,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] thresh,
    input  logic [CW-1:0] limit,
    output logic          fault
);

    logic [DW-1:0] diff;
    logic [CW-1:0] run;
    logic [CW:0]   run_nx;
    logic [CW:0]   lim;

    assign diff   = (a >= b) ? a - b : b - a;
    assign lim    = (limit == '0) ? (CW+1)'(1) : {1'b0, limit};
    assign run_nx = {1'b0, run} + (CW+1)'(1);

    always_ff @(posedge clk) begin
        if (clr) begin
            run   <= '0;
            fault <= 1'b0;
        end else if (run_en && samp_vld) begin
            if (diff > thresh) begin
                if (run_nx >= lim) fault <= 1'b1;
                if (!(&run)) run <= run + 1'b1;
            end else begin
                run <= '0;
            end
        end
    end

endmodule

// File: rtl/xr_omux.sv
module xr_omux #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          samp_vld,
    input  logic          sel,
    input  logic          sel_en,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          out_vld,
    output logic [DW-1:0] out_data
);

    // Selection is sampled together with the strobe, so a swap lands between samples
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= samp_vld && sel_en;
            if (samp_vld && sel_en) out_data <= sel ? b : a;
        end
    end

endmodule

// File: rtl/xcvr_redund_mgr.sv
module xcvr_redund_mgr
    import xr_pkg::*;
#(
    parameter int DW = 12,
    parameter int TW = 24,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode_sel,
    input  logic          prim_fail,
    input  logic [TW-1:0] toggle_interval,
    input  logic [TW-1:0] cfg_timeout,
    input  logic [DW-1:0] diff_thresh,
    input  logic [CW-1:0] mismatch_limit,
    input  logic [1:0]    cfg_done,
    output logic [1:0]    cfg_req,
    output logic [1:0]    unit_pwr,
    output logic [1:0]    unit_en,
    input  logic          samp_vld,
    input  logic [DW-1:0] samp_a,
    input  logic [DW-1:0] samp_b,
    output logic          out_vld,
    output logic [DW-1:0] out_data,
    output logic          active_unit,
    output logic [1:0]    unit_failed,
    output logic          fault
);

    logic [1:0] mode_q;
    mode_e      md;
    logic       mode_chg;
    logic       clr;
    unit_ctl_t  ctl;

    always_ff @(posedge clk) begin
        mode_q <= mode_sel;
    end

    assign md       = dec_mode(mode_q);
    assign mode_chg = (mode_sel != mode_q);
    assign clr      = rst || mode_chg;

    xr_ctrl #(.TW(TW)) u_ctrl (
        .clk       (clk),
        .clr       (clr),
        .mode      (md),
        .prim_fail (prim_fail),
        .cfg_done  (cfg_done),
        .interval  (toggle_interval),
        .timeout   (cfg_timeout),
        .ctl       (ctl),
        .failed    (unit_failed)
    );

    xr_cmp #(.DW(DW), .CW(CW)) u_cmp (
        .clk      (clk),
        .clr      (clr),
        .run_en   (md == MD_CMP),
        .samp_vld (samp_vld),
        .a        (samp_a),
        .b        (samp_b),
        .thresh   (diff_thresh),
        .limit    (mismatch_limit),
        .fault    (fault)
    );

    xr_omux #(.DW(DW)) u_omux (
        .clk      (clk),
        .rst      (rst),
        .samp_vld (samp_vld),
        .sel      (ctl.act),
        .sel_en   (ctl.en[ctl.act]),
        .a        (samp_a),
        .b        (samp_b),
        .out_vld  (out_vld),
        .out_data (out_data)
    );

    assign cfg_req     = ctl.req;
    assign unit_pwr    = ctl.pwr;
    assign unit_en     = ctl.en;
    assign active_unit = ctl.act;

endmodule

// File: rtl/xr_mgr_chk.sv
module xr_mgr_chk
    import xr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       mode_chg,
    input mode_e      md,
    input logic [1:0] cfg_req,
    input logic [1:0] unit_pwr,
    input logic [1:0] unit_en,
    input logic [1:0] unit_failed,
    input logic       fault,
    input logic       samp_vld,
    input logic       out_vld
);

    assert_one_req_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cfg_req));

    assert_cold_backup_off_R2: assert property (@(posedge clk) disable iff (rst)
        (md == MD_COLD && !unit_failed[0]) |-> !unit_pwr[1]);

    assert_single_live_R6: assert property (@(posedge clk) disable iff (rst)
        (md == MD_TGL) |-> $onehot0(unit_en));

    assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (fault && !mode_chg) |=> fault);

    assert_fail_a_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (unit_failed[0] && !mode_chg) |=> unit_failed[0]);

    assert_fail_b_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (unit_failed[1] && !mode_chg) |=> unit_failed[1]);

    assert_out_after_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(samp_vld));

endmodule

bind xcvr_redund_mgr xr_mgr_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_chg    (mode_chg),
    .md          (md),
    .cfg_req     (cfg_req),
    .unit_pwr    (unit_pwr),
    .unit_en     (unit_en),
    .unit_failed (unit_failed),
    .fault       (fault),
    .samp_vld    (samp_vld),
    .out_vld     (out_vld)
);

// File: tb/test_xcvr_redund_mgr.sv
`timescale 1ns/1ps
module test_xcvr_redund_mgr;

    localparam int DW = 12;
    localparam int TW = 24;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode_sel = 2'd0;
    logic          prim_fail = 1'b0;
    logic [TW-1:0] toggle_interval = TW'(20);
    logic [TW-1:0] cfg_timeout = TW'(50);
    logic [DW-1:0] diff_thresh = DW'(3);
    logic [CW-1:0] mismatch_limit = CW'(4);
    logic [1:0]    cfg_done = 2'b00;
    logic [1:0]    cfg_req, unit_pwr, unit_en, unit_failed;
    logic          samp_vld = 1'b0;
    logic [DW-1:0] samp_a = '0, samp_b = '0;
    logic          out_vld, active_unit, fault;
    logic [DW-1:0] out_data;

    xcvr_redund_mgr #(.DW(DW), .TW(TW), .CW(CW)) i_xcvr_redund_mgr (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .prim_fail(prim_fail),
        .toggle_interval(toggle_interval), .cfg_timeout(cfg_timeout),
        .diff_thresh(diff_thresh), .mismatch_limit(mismatch_limit),
        .cfg_done(cfg_done), .cfg_req(cfg_req), .unit_pwr(unit_pwr), .unit_en(unit_en),
        .samp_vld(samp_vld), .samp_a(samp_a), .samp_b(samp_b),
        .out_vld(out_vld), .out_data(out_data), .active_unit(active_unit),
        .unit_failed(unit_failed), .fault(fault)
    );

    always #2.5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    int len [2] = '{8, 8};
    int cnt [2] = '{0, 0};
    int cyc = 0;
    bit auto_s = 1;
    int boff = 0;

    // Behavioural reference state
    int m_mode, m_st, m_act, m_tmr, m_fault, m_run, m_ov, m_od;
    bit [1:0] m_fail;

    function automatic int fdec(int m);
        return (m == 3) ? 0 : m;
    endfunction

    function automatic bit mpwr(int md, int act, bit [1:0] f, int u);
        if (f[u]) return 1'b0;
        if (md == 0) return u == act;
        return 1'b1;
    endfunction

    function automatic bit men(int md, int st, int act, bit [1:0] f, int u);
        if (f[u]) return 1'b0;
        if (md == 1) return 1'b1;
        if (md == 2) return u == act;
        return (u == act) && (st != 1);
    endfunction

    function automatic bit mreq(int md, int st, int act, int u);
        if (st != 1) return 1'b0;
        return u == ((md == 2) ? 1 - act : act);
    endfunction

    always @(posedge clk) begin
        int md, tgt, d, lim;
        if (rst) begin
            m_mode = int'(mode_sel);
            m_st = 0; m_act = 0; m_tmr = 0; m_fail = 0;
            m_fault = 0; m_run = 0; m_ov = 0; m_od = 0;
        end else begin
            md = fdec(m_mode);
            if (samp_vld && men(md, m_st, m_act, m_fail, m_act)) begin
                m_ov = 1;
                m_od = (m_act == 1) ? int'(samp_b) : int'(samp_a);
            end else begin
                m_ov = 0;
            end
            if (int'(mode_sel) != m_mode) begin
                m_st = 0; m_act = 0; m_tmr = 0; m_fail = 0; m_fault = 0; m_run = 0;
                m_mode = int'(mode_sel);
            end else begin
                if (md == 1 && samp_vld) begin
                    d = int'(samp_a) - int'(samp_b);
                    if (d < 0) d = -d;
                    if (d > int'(diff_thresh)) begin
                        lim = (mismatch_limit == 0) ? 1 : int'(mismatch_limit);
                        if (m_run + 1 >= lim) m_fault = 1;
                        if (m_run < 255) m_run++;
                    end else begin
                        m_run = 0;
                    end
                end
                tgt = (md == 2) ? 1 - m_act : m_act;
                case (m_st)
                    0: if (md == 2) begin
                           m_st = 1; m_tmr = 0;
                       end else if (md == 0 && prim_fail) begin
                           m_fail[m_act] = 1'b1; m_act = 1 - m_act; m_st = 1; m_tmr = 0;
                       end
                    1: begin
                           if (cfg_done[tgt]) m_st = (md == 2) ? 2 : 3;
                           else if (m_tmr >= int'(cfg_timeout)) begin
                               m_fail[tgt] = 1'b1; m_st = 3;
                           end
                           m_tmr++;
                       end
                    2: begin
                           if (m_tmr >= int'(toggle_interval)) begin
                               m_act = 1 - m_act; m_st = 1; m_tmr = 0;
                           end else begin
                               m_tmr++;
                           end
                       end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    task automatic step();
        int md;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (!rst) begin
            md = fdec(m_mode);
            chk("R6 cfg_req", int'(cfg_req),
                2*int'(mreq(md, m_st, m_act, 1)) + int'(mreq(md, m_st, m_act, 0)));
            chk("R10 unit_pwr", int'(unit_pwr),
                2*int'(mpwr(md, m_act, m_fail, 1)) + int'(mpwr(md, m_act, m_fail, 0)));
            chk("R2 unit_en", int'(unit_en),
                2*int'(men(md, m_st, m_act, m_fail, 1)) + int'(men(md, m_st, m_act, m_fail, 0)));
            chk("R8 unit_failed", int'(unit_failed), int'(m_fail));
            chk("R7 active_unit", int'(active_unit), m_act);
            chk("R5 fault", int'(fault), m_fault);
            chk("R9 out_vld", int'(out_vld), m_ov);
            chk("R9 out_data", int'(out_data), m_od);
        end
        for (int u = 0; u < 2; u++) begin
            if (cfg_req[u]) begin
                cfg_done[u] = (cnt[u] == len[u]);
                cnt[u]++;
            end else begin
                cnt[u] = 0;
                cfg_done[u] = 1'b0;
            end
        end
        if (auto_s) begin
            samp_vld = (cyc % 3) != 2;
            samp_a   = DW'(cyc * 5);
            samp_b   = samp_a + DW'(boff);
        end
    endtask

    task automatic send(int a, int b);
        samp_vld = 1'b1; samp_a = DW'(a); samp_b = DW'(b);
        step();
        samp_vld = 1'b0;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int swaps, prev;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1: reset state, cold standby with A live
        chk("R1 reset active_unit", int'(active_unit), 0);
        chk("R1 reset failed", int'(unit_failed), 0);
        chk("R1 reset fault", int'(fault), 0);
        chk("R2 reset pwr A only", int'(unit_pwr), 1);
        chk("R2 reset en A only", int'(unit_en), 1);

        // Cold standby: primary fails, backup brought up
        repeat (10) step();
        len[1] = 5;
        prim_fail = 1'b1; step(); prim_fail = 1'b0;
        repeat (15) step();
        chk("R3 backup enabled", int'(unit_en), 2);
        chk("R3 backup powered", int'(unit_pwr), 2);
        chk("R3 primary failed", int'(unit_failed), 1);
        chk("R3 active is B", int'(active_unit), 1);
        prim_fail = 1'b1; step(); prim_fail = 1'b0;
        repeat (3) step();
        chk("R3 second pulse ignored", int'(active_unit), 1);
        chk("R3 second pulse failed", int'(unit_failed), 1);

        // Comparison mode
        auto_s = 0; samp_vld = 1'b0;
        mode_sel = 2'd1;
        step(); step();
        chk("R1 mode change clears failed", int'(unit_failed), 0);
        chk("R1 mode change active A", int'(active_unit), 0);
        chk("R4 both enabled", int'(unit_en), 3);
        chk("R4 both powered", int'(unit_pwr), 3);
        send(100, 103); send(103, 100);
        send(100, 110); send(100, 110); send(100, 110);
        send(50, 50);
        send(200, 190); send(200, 190); send(200, 190);
        chk("R5 three mismatches no fault", int'(fault), 0);
        send(200, 190);
        chk("R5 fourth mismatch faults", int'(fault), 1);
        send(7, 7);
        chk("R5 fault sticky", int'(fault), 1);
        chk("R4 forwards A", int'(out_data), 7);
        mode_sel = 2'd0; step();
        mode_sel = 2'd1; mismatch_limit = '0; step(); step();
        chk("R1 mode change clears fault", int'(fault), 0);
        send(10, 20);
        chk("R5 limit zero acts as one", int'(fault), 1);

        // Toggling, interval dominates
        auto_s = 1; mismatch_limit = CW'(4);
        len[0] = 8; len[1] = 8;
        toggle_interval = TW'(20); cfg_timeout = TW'(50);
        mode_sel = 2'd2;
        swaps = 0; prev = 0;
        for (int i = 0; i < 200; i++) begin
            step();
            if (int'(active_unit) != prev) swaps++;
            prev = int'(active_unit);
        end
        chk("R7 swaps occurred", int'(swaps >= 5), 1);

        // Toggling, configuration time dominates
        toggle_interval = TW'(2); len[0] = 12; len[1] = 12;
        repeat (100) step();

        // Timeout on the standby unit
        mode_sel = 2'd0; step();
        len[1] = 1000000; cfg_timeout = TW'(30);
        mode_sel = 2'd2;
        repeat (60) step();
        chk("R8 standby marked failed", int'(unit_failed), 2);
        chk("R8 stays on A", int'(active_unit), 0);
        chk("R8 only A powered", int'(unit_pwr), 1);
        chk("R8 request dropped", int'(cfg_req), 0);
        chk("R10 failed unit disabled", int'(unit_en), 1);

        // Reserved encoding behaves as cold standby
        mode_sel = 2'd3;
        step(); step();
        chk("R1 code 3 cold pwr", int'(unit_pwr), 1);
        chk("R1 code 3 cold en", int'(unit_en), 1);
        chk("R1 code 3 failed cleared", int'(unit_failed), 0);
        repeat (5) step();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule